// File: doc/BRIEF.md
# GPIO Bank Register File with Masked Writes

This block holds the control state for one bank of general-purpose pins, split into a configurable number of ports of up to eight pins each. Per port, software reaches four register groups over a word-addressed register bus. The groups are pin mode, output enable, output value and a read-only input sample. The block drives the pad output and pad output-enable lines from that state. It also feeds the pad levels back through a two-flop synchronizer into the input-sample registers.

The mode, output-enable and output-value groups are also reachable through a second, masked alias placed a parameterized distance above the plain map. A write to the alias uses bits 15:8 as per-pin write enables and bits 7:0 as the new pin levels. Software can therefore change single pins atomically, with no read-modify-write. A pin whose mode bit is clear is not under register control: its pad output and enable pass through from an alternate-function input.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every mode, output-enable and output-value register reads zero, and with the alternate-function enable held at zero all pad output enables are zero.
- R2: A plain write at byte offset group*0x10 + port*4 (group 0 mode, 1 output enable, 2 output value) loads wdata bits 7:0 into that port's register. A read at the same offset returns the value in bits 7:0 and zero in bits 31:8.
- R3: A write to the masked alias at MASK_OFS + group*0x10 + port*4 (groups 0 to 2) updates pin i to wdata bit i only where wdata bit 8+i is set. All other pins of that register keep their value.
- R4: A masked write whose enable byte (bits 15:8) is zero changes no register.
- R5: For a pin whose mode bit is 1, the pad output equals its output-value bit and the pad output enable equals its output-enable bit.
- R6: For a pin whose mode bit is 0, the pad output and pad output enable equal the alternate-function output and enable inputs for that pin.
- R7: The input-sample register of a port (group 3, offset 0x30 + port*4) returns the pad input levels delayed by exactly two clock edges.
- R8: The input-sample register is read-only: writes to it change no register.
- R9: Reads of the masked alias, of the masked input-sample slot (MASK_OFS + 0x30 + port*4), of offsets with nonzero bits 1:0 and of offsets outside both maps return zero. Writes to those offsets change no register.
- R10: A write to one port's register changes no register of any other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while a read is requested (combinational) |
| pad_i | input | PORTS*PINS | Pad input levels |
| alt_out_i | input | PORTS*PINS | Alternate-function pad output |
| alt_oe_i | input | PORTS*PINS | Alternate-function pad output enable |
| pad_out_o | output | PORTS*PINS | Pad output |
| pad_oe_o | output | PORTS*PINS | Pad output enable |

## Verification
The embedded properties assume that every bus access lasts a single cycle with stable address and data, and that MASK_OFS lies above the plain map (at least 0x40), so that no address hits both maps. The two-edge input-latency property also assumes that reset has been released for at least two cycles. The bench drives each access at the falling edge and holds it for one full cycle. It uses only the default alias offset of 0x80 and changes pad inputs only between edges, so the stimulus stays inside these assumptions.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned PORT_IDX_W = 2;

  typedef enum logic [1:0] {
    GRP_MODE = 2'd0,
    GRP_OE   = 2'd1,
    GRP_OUT  = 2'd2,
    GRP_IN   = 2'd3
  } grp_e;

  typedef struct packed {
    logic                  hit;
    logic                  masked;
    grp_e                  grp;
    logic [PORT_IDX_W-1:0] port;
  } dec_t;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PORTS    = 4,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned MASK_OFS = 'h80
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);

  localparam int unsigned PLAIN_END = 'h40;
  localparam int unsigned MASK_END  = MASK_OFS + 'h30; // no masked input slot

  logic              in_plain, in_mask;
  logic [ADDR_W-1:0] rel;

  always_comb begin
    in_plain     = addr_i < ADDR_W'(PLAIN_END);
    in_mask      = (addr_i >= ADDR_W'(MASK_OFS)) && (addr_i < ADDR_W'(MASK_END));
    rel          = in_mask ? addr_i - ADDR_W'(MASK_OFS) : addr_i;
    dec_o.masked = in_mask;
    dec_o.grp    = grp_e'(rel[5:4]);
    dec_o.port   = rel[3:2];
    dec_o.hit    = (in_plain || in_mask) && (rel[1:0] == 2'b00) &&
                   (32'(rel[3:2]) < PORTS);
  end

endmodule

// File: rtl/gpio_port_reg.sv
module gpio_port_reg
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  grp_e            grp_i,
  input  logic            masked_i,
  input  logic [15:0]     wdata_i,
  input  logic [PINS-1:0] alt_out_i,
  input  logic [PINS-1:0] alt_oe_i,
  output logic [PINS-1:0] mode_o,
  output logic [PINS-1:0] oe_o,
  output logic [PINS-1:0] out_o,
  output logic [PINS-1:0] pad_out_o,
  output logic [PINS-1:0] pad_oe_o
);

  logic [PINS-1:0] mode_q, oe_q, out_q;
  logic [PINS-1:0] wen, wval;

  assign wen  = wdata_i[8 +: PINS];
  assign wval = wdata_i[0 +: PINS];

  function automatic logic [PINS-1:0] merge(logic [PINS-1:0] cur, logic msk,
                                            logic [PINS-1:0] en, logic [PINS-1:0] val);
    return msk ? ((cur & ~en) | (val & en)) : val;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      oe_q   <= '0;
      out_q  <= '0;
    end else if (wr_i) begin
      unique case (grp_i)
        GRP_MODE: mode_q <= merge(mode_q, masked_i, wen, wval);
        GRP_OE:   oe_q   <= merge(oe_q, masked_i, wen, wval);
        GRP_OUT:  out_q  <= merge(out_q, masked_i, wen, wval);
        default:  ;
      endcase
    end
  end

  // register control only where the pin is in GPIO mode
  assign pad_out_o = (mode_q & out_q) | (~mode_q & alt_out_i);
  assign pad_oe_o  = (mode_q & oe_q)  | (~mode_q & alt_oe_i);
  assign mode_o    = mode_q;
  assign oe_o      = oe_q;
  assign out_o     = out_q;

  // R3
  masked_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && masked_i && grp_i == GRP_OUT) |=>
      (((out_q ^ $past(out_q)) & ~$past(wen)) == '0));

  // R4
  masked_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && masked_i && wen == '0) |=>
      ($stable(mode_q) && $stable(oe_q) && $stable(out_q)));

  // R10
  port_isolation_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(mode_q) && $stable(oe_q) && $stable(out_q)));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_lat_chk
      logic [1:0] age_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
      end
      // R7
      sync_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd2) |-> (q_o == $past(d_i, 2)));
    end
  endgenerate

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PORTS    = 4,
  parameter int unsigned PINS     = 8,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned MASK_OFS = 'h80,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic [PORTS*PINS-1:0] pad_i,
  input  logic [PORTS*PINS-1:0] alt_out_i,
  input  logic [PORTS*PINS-1:0] alt_oe_i,
  output logic [PORTS*PINS-1:0] pad_out_o,
  output logic [PORTS*PINS-1:0] pad_oe_o
);

  localparam int unsigned NPIN = PORTS * PINS;

  dec_t            dec;
  logic [NPIN-1:0] mode_all, oe_all, out_all, in_all;
  logic            bus_wr;

  assign bus_wr = req_i && we_i && dec.hit;

  gpio_addr_dec #(
    .PORTS(PORTS), .ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS)
  ) u_dec (
    .addr_i(addr_i),
    .dec_o (dec)
  );

  gpio_in_sync #(.W(NPIN), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (in_all)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    gpio_port_reg #(.PINS(PINS)) u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (bus_wr && (32'(dec.port) == p)),
      .grp_i    (dec.grp),
      .masked_i (dec.masked),
      .wdata_i  (wdata_i[15:0]),
      .alt_out_i(alt_out_i[p*PINS +: PINS]),
      .alt_oe_i (alt_oe_i[p*PINS +: PINS]),
      .mode_o   (mode_all[p*PINS +: PINS]),
      .oe_o     (oe_all[p*PINS +: PINS]),
      .out_o    (out_all[p*PINS +: PINS]),
      .pad_out_o(pad_out_o[p*PINS +: PINS]),
      .pad_oe_o (pad_oe_o[p*PINS +: PINS])
    );
  end

  // masked aliases are write-only
  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i && dec.hit && !dec.masked) begin
      unique case (dec.grp)
        GRP_MODE: rdata_o[PINS-1:0] = mode_all[32'(dec.port)*PINS +: PINS];
        GRP_OE:   rdata_o[PINS-1:0] = oe_all[32'(dec.port)*PINS +: PINS];
        GRP_OUT:  rdata_o[PINS-1:0] = out_all[32'(dec.port)*PINS +: PINS];
        default:  rdata_o[PINS-1:0] = in_all[32'(dec.port)*PINS +: PINS];
      endcase
    end
  end

  // R8
  input_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr && dec.grp == GRP_IN) |=>
      ($stable(mode_all) && $stable(oe_all) && $stable(out_all)));

  // R9
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !dec.hit) |-> (rdata_o == '0));

  // R9
  unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !dec.hit) |=>
      ($stable(mode_all) && $stable(oe_all) && $stable(out_all)));

  // R2
  readback_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |-> (rdata_o[31:PINS] == '0));

endmodule

// File: tb/gpio_bank_regs_test.sv
module gpio_bank_regs_test;

  localparam int unsigned PORTS = 4;
  localparam int unsigned PINS  = 8;
  localparam int unsigned NPIN  = PORTS * PINS;
  localparam int unsigned AW    = 12;
  localparam int unsigned MOFS  = 'h80;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0]   addr_i = '0;
  logic [31:0]     wdata_i = '0, rdata_o;
  logic [NPIN-1:0] pad_i = '0, alt_out_i = '0, alt_oe_i = '0;
  logic [NPIN-1:0] pad_out_o, pad_oe_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_mode [PORTS];
  logic [7:0] m_oe   [PORTS];
  logic [7:0] m_out  [PORTS];

  always #4 clk_i = ~clk_i;

  gpio_bank_regs #(.PORTS(PORTS), .PINS(PINS), .ADDR_W(AW), .MASK_OFS(MOFS)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pad_i(pad_i), .alt_out_i(alt_out_i),
    .alt_oe_i(alt_oe_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0; wdata_i = '0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    req_i = 0;
  endtask

  function automatic logic [7:0] apply(logic [7:0] cur, logic msk, logic [31:0] d);
    return msk ? ((cur & ~d[15:8]) | (d[7:0] & d[15:8])) : d[7:0];
  endfunction

  // model update for a write to group g, port p
  task automatic wr_reg(input int g, input int p, input logic msk, input logic [31:0] d);
    bus_wr(AW'((msk ? MOFS : 0) + g * 16 + p * 4), d);
    case (g)
      0: m_mode[p] = apply(m_mode[p], msk, d);
      1: m_oe[p]   = apply(m_oe[p], msk, d);
      2: m_out[p]  = apply(m_out[p], msk, d);
      default: ;
    endcase
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    for (int p = 0; p < PORTS; p++) begin
      bus_rd(AW'(p * 4), d);        chk({tag, " mode"}, d, {24'h0, m_mode[p]});
      bus_rd(AW'(16 + p * 4), d);   chk({tag, " oe"},   d, {24'h0, m_oe[p]});
      bus_rd(AW'(32 + p * 4), d);   chk({tag, " out"},  d, {24'h0, m_out[p]});
    end
  endtask

  task automatic check_pads(input string tag);
    logic [NPIN-1:0] mo, oo, vo;
    for (int p = 0; p < PORTS; p++) begin
      mo[p*8 +: 8] = m_mode[p]; oo[p*8 +: 8] = m_oe[p]; vo[p*8 +: 8] = m_out[p];
    end
    @(negedge clk_i); #1;
    chk({tag, " pad_oe"},  pad_oe_o,  (mo & oo) | (~mo & alt_oe_i));
    chk({tag, " pad_out"}, pad_out_o, (mo & vo) | (~mo & alt_out_i));
  endtask

  task automatic t_reset();
    for (int p = 0; p < PORTS; p++) begin m_mode[p] = 0; m_oe[p] = 0; m_out[p] = 0; end
    check_all("R1 reset");
    @(negedge clk_i); #1;
    chk("R1 pad_oe after reset", pad_oe_o, '0);
  endtask

  task automatic t_plain();
    logic [31:0] d;
    wr_reg(0, 2, 0, 32'hFFFF_FF5A);
    wr_reg(1, 1, 0, 32'hDEAD_BE3C);
    wr_reg(2, 3, 0, 32'h0000_00C3);
    bus_rd(AW'(16 + 4), d);
    chk("R2 oe readback upper zero", d, 32'h0000_003C);
    check_all("R2 plain write");
  endtask

  task automatic t_masked();
    wr_reg(2, 0, 0, 32'h0000_00F0);
    wr_reg(2, 0, 1, 32'h0000_3C0F);   // pins 2..5 only
    chk("R3 masked out port0", {24'h0, m_out[0]}, 32'h0000_00CC);
    wr_reg(0, 1, 1, 32'h0000_8181);
    wr_reg(1, 3, 1, 32'h0000_FFA5);
    check_all("R3 masked write");
  endtask

  task automatic t_masked_zero();
    wr_reg(0, 2, 1, 32'h0000_00FF);
    wr_reg(2, 3, 1, 32'h0000_0000);
    check_all("R4 zero enable");
  endtask

  task automatic t_pad_mux();
    alt_out_i = 32'hA5A5_5A5A;
    alt_oe_i  = 32'h0F0F_F0F0;
    wr_reg(0, 0, 0, 32'h0000_000F);
    wr_reg(1, 0, 0, 32'h0000_0033);
    wr_reg(2, 0, 0, 32'h0000_0055);
    check_pads("R5 R6 mixed");
    wr_reg(0, 0, 0, 32'h0000_00FF);
    check_pads("R5 all gpio");
    wr_reg(0, 0, 0, 32'h0000_0000);
    wr_reg(0, 1, 0, 32'h0000_0000);
    wr_reg(0, 2, 0, 32'h0000_0000);
    wr_reg(0, 3, 0, 32'h0000_0000);
    check_pads("R6 all alternate");
  endtask

  task automatic t_input_sync();
    @(negedge clk_i);
    pad_i = 32'h1234_5678;
    repeat (3) @(negedge clk_i);
    pad_i = 32'h9ABC_DEF0;
    req_i = 1; we_i = 0; addr_i = AW'('h34);   // port1 input
    @(posedge clk_i); #1;
    chk("R7 one edge keeps old", rdata_o, 32'h0000_0056);
    @(posedge clk_i); #1;
    chk("R7 two edges shows new", rdata_o, 32'h0000_00DE);
    @(negedge clk_i);
    addr_i = AW'('h3C);
    #1 chk("R7 port3 input", rdata_o, 32'h0000_009A);
    req_i = 0;
  endtask

  task automatic t_input_ro();
    logic [31:0] d;
    wr_reg(3, 0, 0, 32'h0000_FFFF);
    wr_reg(3, 2, 0, 32'h0000_0000);
    check_all("R8 input write ignored");
    bus_rd(AW'('h30), d);
    chk("R8 input still pad", d, 32'h0000_00F0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_rd(AW'(MOFS), d);          chk("R9 masked alias read", d, 0);
    bus_rd(AW'(MOFS + 'h24), d);   chk("R9 masked out read", d, 0);
    bus_rd(AW'(MOFS + 'h30), d);   chk("R9 masked input read", d, 0);
    bus_rd(AW'('h40), d);          chk("R9 past plain map", d, 0);
    bus_rd(AW'('h22), d);          chk("R9 misaligned read", d, 0);
    bus_wr(AW'(MOFS + 'h30), 32'h0000_FFFF);
    bus_wr(AW'(MOFS + 'h34), 32'h0000_FFFF);
    bus_wr(AW'('h41), 32'h0000_FFFF);
    bus_wr(AW'('h02), 32'h0000_00FF);
    bus_wr(AW'('h7FC), 32'h0000_FFFF);
    check_all("R9 unmapped write ignored");
  endtask

  task automatic t_isolation();
    for (int p = 0; p < PORTS; p++) begin
      wr_reg(0, p, 0, 32'(8'h11 * (p + 1)));
      wr_reg(1, p, 0, 32'(8'h22 + p));
      wr_reg(2, p, 0, 32'(8'h40 + p));
    end
    wr_reg(2, 2, 0, 32'h0000_00EE);
    wr_reg(1, 1, 1, 32'h0000_0F0F);
    check_all("R10 port isolation");
    check_pads("R10 pads");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_plain();
    t_masked();
    t_masked_zero();
    t_pad_mux();
    t_input_sync();
    t_input_ro();
    t_unmapped();
    t_isolation();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule